// File: doc/BRIEF.md
# Run-Time ECC-Driven Spare Word Repair Controller

This controller wraps a word-addressed RAM whose words are stored as 22-bit codewords: 16 data bits plus 6 check bits of a single-error-correct, double-error-detect code. A requester issues reads and writes through a ready/request handshake. The controller encodes write data, decodes read data, and returns the corrected word. The physical RAM and a bank of eight spare words sit outside the block, behind one memory port.

A read that shows a correctable error starts an identification step. The controller writes the corrected codeword back to the same physical word and reads that word again. A clean re-read marks the upset as transient, and nothing more happens. An error on the re-read marks a permanent fault. The logical address is then bound to the lowest-numbered free spare word, and the corrected codeword is written into that spare. From then on, every access to that address goes to the spare, with no added latency, because the spare lookup is combinational in the accept cycle. A spare that later fails the same check is retired and replaced. A double-bit error sets a sticky uncorrectable flag and starts no repair. A permanent fault found when no spare is left sets a sticky exhausted flag and leaves the mapping unchanged.

Top module: `word_repair_ctrl`

## Requirements
- R1: Writes store the 16-bit data as a 22-bit SEC/DED codeword. A read accepted at a clock edge raises `rvalid` for exactly the next cycle, with `rdata` equal to the stored data, even when one codeword bit has flipped.
- R2: The spare lookup adds no cycles. An accepted write drives a memory write in the same cycle as the accept. An accepted read drives a memory read in the same cycle as the accept.
- R3: When a read shows a single-bit error, the controller writes the corrected codeword back to the same physical word and then reads that word again.
- R4: A clean re-read classes the error as soft. No spare is assigned, and later accesses to that address still use the main word.
- R5: An error on the re-read classes the fault as hard. The lowest-index free spare is bound to the address and receives the corrected codeword. Main word `a` sits at `mem_addr = a`, and spare `k` sits at `mem_addr = 2^ADDR_W + k`, so its MSB is set. Later reads and writes of the address go to the spare.
- R6: Suppose a hard fault is found in a spare already bound to an address, and a free spare exists. That spare is marked faulty and never matched again. The address moves to the lowest free spare, which receives the corrected codeword.
- R7: `ready` is high only when the controller is idle. It stays low for 1 cycle after a clean or double-error read, 4 cycles after a soft error, 5 cycles after a hard repair, and 4 cycles after a hard fault with no free spare. A request held during that time is served once `ready` returns.
- R8: A double-bit error raises `ue_flag` and causes no write-back. The flag stays set until `flag_clr` is pulsed.
- R9: A hard fault found with no free spare raises `exhaust_flag`, which is sticky until `flag_clr`. The mapping stays unchanged, and later reads of the address still return ECC-corrected data.
- R10: After reset, `ready` is high, both flags and `rvalid` are low, and no spare is bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Requester access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical word address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Controller idle; request accepted when req is high |
| rvalid | output | 1 | Read data valid, cycle after read accept |
| rdata | output | 16 | Corrected read data |
| ue_flag | output | 1 | Sticky uncorrectable error flag |
| exhaust_flag | output | 1 | Sticky no-spare-left flag |
| flag_clr | input | 1 | Clears both sticky flags |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W+1 | Physical word: main below 2^ADDR_W, spares above |
| mem_wcode | output | 22 | Codeword to write |
| mem_rcode | input | 22 | Codeword read, valid the cycle after a read |

## Verification
The bench drives reads in several forms: clean codewords, a one-time flipped bit, two flipped bits, a stuck bit in a main word, and a stuck bit in a spare already in use. It tells these cases apart by the number of stalled cycles, the number of memory writes, and the physical address of the next access. A stuck bit on a series of further addresses fills every spare, which separates an ordinary repair from an exhausted one. A write held high across a soft-error identification shows that stalled requests are neither lost nor overwritten by the write-back.

// File: rtl/wrc_pkg.sv
// Shared types and code geometry for the spare word repair controller.
// Assumes an extended Hamming code: position 0 holds overall parity,
// power-of-two positions hold check bits, the rest hold data.
package wrc_pkg;

    localparam int DATA_W = 16;

    // Smallest number of Hamming check bits covering DATA_W data bits.
    function automatic int hamming_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    localparam int HAM_P = hamming_bits(DATA_W);
    localparam int CW_W  = DATA_W + HAM_P + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRBACK,
        ST_REREAD,
        ST_VERDICT,
        ST_SPARE_WR
    } wrc_state_e;

    // Scatter data bits into the non-check positions of a codeword.
    function automatic code_t place_data(input data_t d);
        code_t c;
        int    k;
        c = '0;
        k = 0;
        for (int i = 1; i < CW_W; i++) begin
            if ((i & (i - 1)) != 0) begin
                c[i] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    // Gather data bits back out of a codeword.
    function automatic data_t take_data(input code_t c);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int i = 1; i < CW_W; i++) begin
            if ((i & (i - 1)) != 0) begin
                d[k] = c[i];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/wrc_secded_enc.sv
// SEC/DED encoder: builds the full codeword for one data word.
// Assumes the position layout of wrc_pkg; purely combinational.
module wrc_secded_enc
    import wrc_pkg::*;
(
    input  data_t data_in,
    output code_t code_out
);

    // Fill data positions, compute each Hamming check, then overall parity.
    always_comb begin
        code_t c;
        logic  par;
        c = place_data(data_in);
        for (int p = 0; p < HAM_P; p++) begin
            par = 1'b0;
            for (int i = 1; i < CW_W; i++) begin
                if (((i >> p) & 1) == 1) par = par ^ c[i];
            end
            c[1 << p] = par;
        end
        c[0] = ^c[CW_W-1:1];
        code_out = c;
    end

endmodule

// File: rtl/wrc_secded_dec.sv
// SEC/DED decoder: reports clean, single (corrected) or double error.
// Assumes the position layout of wrc_pkg; purely combinational.
module wrc_secded_dec
    import wrc_pkg::*;
(
    input  code_t code_in,
    output data_t data_out,
    output logic  err_single,
    output logic  err_double
);

    logic [HAM_P-1:0] syn;
    logic             ovr;
    logic             in_range;
    code_t            fixed;

    // Syndrome over the Hamming positions plus overall parity check.
    always_comb begin
        syn = '0;
        for (int p = 0; p < HAM_P; p++) begin
            for (int i = 1; i < CW_W; i++) begin
                if (((i >> p) & 1) == 1) syn[p] = syn[p] ^ code_in[i];
            end
        end
        ovr      = ^code_in;
        in_range = (int'(syn) < CW_W);
    end

    // Flip the bit the syndrome points at when a single error is seen.
    always_comb begin
        fixed = code_in;
        if (ovr && in_range) begin
            for (int i = 0; i < CW_W; i++) begin
                if (int'(syn) == i) fixed[i] = ~code_in[i];
            end
        end
    end

    assign err_single = ovr && in_range;
    assign err_double = (!ovr && (syn != '0)) || (ovr && !in_range);
    assign data_out   = take_data(fixed);

endmodule

// File: rtl/wrc_remap_table.sv
// Spare binding table: one entry per spare word holding bound, retired and
// the logical address tag. Lookup is combinational; allocation always
// takes the lowest unbound entry. Assumes at most one alloc per cycle.
module wrc_remap_table #(
    parameter int NSPARE = 8,
    parameter int TAG_W  = 6,
    localparam int IDX_W = (NSPARE > 1) ? $clog2(NSPARE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [NSPARE-1:0] lk_match,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              retire_en,
    input  logic [IDX_W-1:0]  retire_idx,
    output logic              free_any,
    output logic [IDX_W-1:0]  free_idx,
    output logic [NSPARE-1:0] bound_vec,
    output logic [NSPARE-1:0] retired_vec
);

    logic [TAG_W-1:0] tag_q [NSPARE];

    for (genvar g = 0; g < NSPARE; g++) begin : g_ent
        // Entry state update: bind on allocation, retire on fault.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bound_vec[g]   <= 1'b0;
                retired_vec[g] <= 1'b0;
                tag_q[g]       <= '0;
            end else begin
                if (alloc_en && (free_idx == IDX_W'(g))) begin
                    bound_vec[g] <= 1'b1;
                    tag_q[g]     <= alloc_tag;
                end
                if (retire_en && (retire_idx == IDX_W'(g))) retired_vec[g] <= 1'b1;
            end
        end
        assign lk_match[g] = bound_vec[g] && !retired_vec[g] && (tag_q[g] == lk_tag);
    end

    // Encode the matching entry index.
    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < NSPARE; i++) begin
            if (lk_match[i]) lk_idx = IDX_W'(i);
        end
    end

    // Lowest unbound entry wins the next allocation.
    always_comb begin
        free_idx = '0;
        for (int i = NSPARE - 1; i >= 0; i--) begin
            if (!bound_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign lk_hit   = |lk_match;
    assign free_any = !(&bound_vec);

endmodule

// File: rtl/word_repair_ctrl.sv
// Run-time repair controller. Serves requester reads and writes through
// the ECC codec and spare table. On a corrected read it writes back,
// re-reads, and binds a spare when the fault persists. Assumes a memory
// with one-cycle read latency; spare k lives at physical 2^ADDR_W + k.
module word_repair_ctrl
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NSPARE = 8,
    localparam int PA_W  = ADDR_W + 1,
    localparam int IDX_W = (NSPARE > 1) ? $clog2(NSPARE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                ready,
    output logic                rvalid,
    output logic [DATA_W-1:0]   rdata,
    output logic                ue_flag,
    output logic                exhaust_flag,
    input  logic                flag_clr,
    output logic                mem_en,
    output logic                mem_we,
    output logic [PA_W-1:0]     mem_addr,
    output logic [CW_W-1:0]     mem_wcode,
    input  logic [CW_W-1:0]     mem_rcode
);

    wrc_state_e        state;
    logic [ADDR_W-1:0] lat_addr;
    logic [PA_W-1:0]   lat_phys;
    logic              lat_hit;
    logic [IDX_W-1:0]  lat_idx;
    logic [IDX_W-1:0]  new_idx;
    code_t             lat_code;

    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [NSPARE-1:0] lk_match;
    logic              free_any;
    logic [IDX_W-1:0]  free_idx;
    logic [NSPARE-1:0] spare_bound;
    logic [NSPARE-1:0] spare_retired;
    logic              alloc_en;
    logic              retire_en;

    code_t             wr_code;
    code_t             fix_code;
    data_t             dec_data;
    logic              dec_single;
    logic              dec_double;
    logic              dec_err;
    logic [PA_W-1:0]   phys_req;

    wrc_remap_table #(.NSPARE(NSPARE), .TAG_W(ADDR_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (req_addr),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_match   (lk_match),
        .alloc_en   (alloc_en),
        .alloc_tag  (lat_addr),
        .retire_en  (retire_en),
        .retire_idx (lat_idx),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .bound_vec  (spare_bound),
        .retired_vec(spare_retired)
    );

    wrc_secded_enc u_enc_wr  (.data_in(req_wdata), .code_out(wr_code));
    wrc_secded_enc u_enc_fix (.data_in(dec_data),  .code_out(fix_code));
    wrc_secded_dec u_dec (
        .code_in   (mem_rcode),
        .data_out  (dec_data),
        .err_single(dec_single),
        .err_double(dec_double)
    );

    assign dec_err   = dec_single || dec_double;
    assign phys_req  = lk_hit ? {1'b1, ADDR_W'(lk_idx)} : {1'b0, req_addr};
    assign alloc_en  = (state == ST_VERDICT) && dec_err && free_any;
    assign retire_en = alloc_en && lat_hit;

    // Sequencer for normal access, identification and spare repair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_addr <= '0;
            lat_phys <= '0;
            lat_hit  <= 1'b0;
            lat_idx  <= '0;
            new_idx  <= '0;
            lat_code <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req && !req_we) begin
                        lat_addr <= req_addr;
                        lat_phys <= phys_req;
                        lat_hit  <= lk_hit;
                        lat_idx  <= lk_idx;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (dec_single) begin
                        lat_code <= fix_code;
                        state    <= ST_WRBACK;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_WRBACK:  state <= ST_REREAD;
                ST_REREAD:  state <= ST_VERDICT;
                ST_VERDICT: begin
                    if (alloc_en) begin
                        new_idx <= free_idx;
                        state   <= ST_SPARE_WR;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_SPARE_WR: state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // Sticky error flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ue_flag      <= 1'b0;
            exhaust_flag <= 1'b0;
        end else begin
            if ((state == ST_CHECK) && dec_double) ue_flag <= 1'b1;
            else if (flag_clr)                     ue_flag <= 1'b0;
            if ((state == ST_VERDICT) && dec_err && !free_any) exhaust_flag <= 1'b1;
            else if (flag_clr)                                 exhaust_flag <= 1'b0;
        end
    end

    // Memory port steering per state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = phys_req;
        mem_wcode = wr_code;
        case (state)
            ST_IDLE: begin
                mem_en = req;
                mem_we = req && req_we;
            end
            ST_WRBACK: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lat_phys;
                mem_wcode = lat_code;
            end
            ST_REREAD: begin
                mem_en   = 1'b1;
                mem_addr = lat_phys;
            end
            ST_SPARE_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {1'b1, ADDR_W'(new_idx)};
                mem_wcode = lat_code;
            end
            default: ;
        endcase
    end

    assign ready  = (state == ST_IDLE);
    assign rvalid = (state == ST_CHECK);
    assign rdata  = rvalid ? dec_data : '0;

endmodule

// File: rtl/wrc_checker.sv
// Property checker for word_repair_ctrl, attached by bind below.
// Observes ports and the spare table state vectors only.
module wrc_checker #(
    parameter int NSPARE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              req_we,
    input logic              ready,
    input logic              rvalid,
    input logic              ue_flag,
    input logic              exhaust_flag,
    input logic              flag_clr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [NSPARE-1:0] lk_match,
    input logic [NSPARE-1:0] spare_bound,
    input logic [NSPARE-1:0] spare_retired
);

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !req_we) |=> rvalid);

    p_write_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && req_we) |-> (mem_en && mem_we));

    p_read_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !req_we) |-> (mem_en && !mem_we));

    p_bind_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(spare_bound) & ~spare_bound) == '0));

    p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    p_retired_is_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((spare_retired & ~spare_bound) == '0));

    p_stall_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !ready);

    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !req) |-> !mem_en);

    p_ue_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag && !flag_clr) |=> ue_flag);

    p_ue_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ue_flag) |-> $past(rvalid));

    p_exhaust_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exhaust_flag && !flag_clr) |=> exhaust_flag);

endmodule

bind word_repair_ctrl wrc_checker #(.NSPARE(NSPARE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .req_we       (req_we),
    .ready        (ready),
    .rvalid       (rvalid),
    .ue_flag      (ue_flag),
    .exhaust_flag (exhaust_flag),
    .flag_clr     (flag_clr),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .lk_match     (lk_match),
    .spare_bound  (spare_bound),
    .spare_retired(spare_retired)
);

// File: tb/word_repair_ctrl_tb_top.sv
// Directed bench: a behavioural RAM with stuck-bit and flip injection,
// one task per scenario, each checking its own results.
module word_repair_ctrl_tb_top;

    localparam int AW   = 6;
    localparam int NSP  = 8;
    localparam int CWB  = 22;
    localparam int PHYS = 128;
    localparam int SP0  = 64;

    logic            clk;
    logic            rst_n;
    logic            req;
    logic            req_we;
    logic [AW-1:0]   req_addr;
    logic [15:0]     req_wdata;
    logic            ready;
    logic            rvalid;
    logic [15:0]     rdata;
    logic            ue_flag;
    logic            exhaust_flag;
    logic            flag_clr;
    logic            mem_en;
    logic            mem_we;
    logic [AW:0]     mem_addr;
    logic [CWB-1:0]  mem_wcode;
    logic [CWB-1:0]  mem_rcode;

    logic [CWB-1:0]  ram   [PHYS];
    logic [CWB-1:0]  stk_m [PHYS];
    logic [CWB-1:0]  stk_v [PHYS];
    logic [AW:0]     flip_a;
    logic [CWB-1:0]  flip_m;
    int              wr_cnt;
    int              last_wr;
    int              last_rd;
    int              compared;
    int              mismatched;
    bit              done;

    word_repair_ctrl #(.ADDR_W(AW), .NSPARE(NSP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rvalid(rvalid), .rdata(rdata), .ue_flag(ue_flag),
        .exhaust_flag(exhaust_flag), .flag_clr(flag_clr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wcode(mem_wcode), .mem_rcode(mem_rcode)
    );

    initial clk = 1'b0;
    always #4ns clk = ~clk;

    // Behavioural RAM: one-cycle read, stuck bits on read, one-shot flips.
    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            ram[mem_addr] <= mem_wcode;
            wr_cnt        <= wr_cnt + 1;
            last_wr       <= int'(mem_addr);
        end else if (mem_en) begin
            mem_rcode <= (ram[mem_addr] & ~stk_m[mem_addr]) | (stk_v[mem_addr] & stk_m[mem_addr]);
            last_rd   <= int'(mem_addr);
        end
        if (flip_m != '0) ram[flip_a] <= ram[flip_a] ^ flip_m;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 1'b0; req_we = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [15:0] dat, output logic rv,
                           output int phys, output int busy, output int nwr, output int lastw);
        int w0;
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = a;
        while (!ready) @(negedge clk);
        w0 = wr_cnt;
        @(negedge clk);
        req  = 1'b0;
        rv   = rvalid;
        dat  = rdata;
        phys = last_rd;
        busy = 0;
        while (!ready) begin
            busy++;
            @(negedge clk);
        end
        nwr   = wr_cnt - w0;
        lastw = last_wr;
    endtask

    task automatic flip_bits(input int p, input logic [CWB-1:0] m);
        @(negedge clk);
        flip_a = (AW+1)'(p); flip_m = m;
        @(negedge clk);
        flip_m = '0;
    endtask

    task automatic make_stuck(input int p, input int b);
        stk_m[p][b] = 1'b1;
        stk_v[p][b] = ~ram[p][b];
    endtask

    task automatic t_reset;
        chk(ready == 1'b1, "R10 ready after reset", int'(ready), 1);
        chk(ue_flag == 1'b0 && exhaust_flag == 1'b0, "R10 flags after reset",
            int'({ue_flag, exhaust_flag}), 0);
        chk(rvalid == 1'b0, "R10 rvalid after reset", int'(rvalid), 0);
    endtask

    task automatic t_clean;
        logic [15:0] d; logic rv; int ph, bz, nw, lw, w0;
        for (int i = 1; i <= 4; i++) begin
            w0 = wr_cnt;
            do_write(AW'(i), 16'h1111 * 16'(i) ^ 16'h8001);
            chk(wr_cnt == w0 + 1 && last_wr == i, "R2 write issued at accept", last_wr, i);
        end
        for (int i = 1; i <= 4; i++) begin
            do_read(AW'(i), d, rv, ph, bz, nw, lw);
            chk(rv == 1'b1 && d == (16'h1111 * 16'(i) ^ 16'h8001), "R1 clean read data",
                int'(d), int'(16'h1111 * 16'(i) ^ 16'h8001));
            chk(ph == i && bz == 1 && nw == 0, "R2 R7 clean read address and stall",
                ph * 100 + bz, i * 100 + 1);
        end
    endtask

    task automatic t_soft;
        logic [15:0] d; logic rv; int ph, bz, nw, lw;
        do_write(6'd10, 16'hA5C3);
        flip_bits(10, 22'h000008);
        do_read(6'd10, d, rv, ph, bz, nw, lw);
        chk(rv == 1'b1 && d == 16'hA5C3, "R1 corrected single flip", int'(d), 16'hA5C3);
        chk(nw == 1 && lw == 10, "R3 write-back to same word", lw * 10 + nw, 101);
        chk(bz == 4, "R7 soft stall length", bz, 4);
        do_read(6'd10, d, rv, ph, bz, nw, lw);
        chk(ph == 10 && bz == 1 && d == 16'hA5C3, "R4 soft error left unmapped", ph * 10 + bz, 101);
    endtask

    task automatic t_stall;
        logic [15:0] d; logic rv; int ph, bz, nw, lw, held;
        do_write(6'd11, 16'h0F0F);
        flip_bits(11, 22'h000100);
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 6'd11;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_we = 1'b1; req_wdata = 16'h7E81;
        held = 0;
        while (!ready) begin
            held++;
            @(negedge clk);
        end
        @(negedge clk);
        req = 1'b0; req_we = 1'b0;
        chk(held == 4, "R7 held write waits for identification", held, 4);
        do_read(6'd11, d, rv, ph, bz, nw, lw);
        chk(d == 16'h7E81, "R7 held write served after stall", int'(d), 16'h7E81);
    endtask

    task automatic t_hard;
        logic [15:0] d; logic rv; int ph, bz, nw, lw;
        do_write(6'd20, 16'h3C5A);
        make_stuck(20, 5);
        do_read(6'd20, d, rv, ph, bz, nw, lw);
        chk(d == 16'h3C5A, "R5 data on hard fault", int'(d), 16'h3C5A);
        chk(nw == 2 && lw == SP0, "R5 repair writes spare 0", lw * 10 + nw, SP0 * 10 + 2);
        chk(bz == 5, "R7 hard repair stall length", bz, 5);
        do_read(6'd20, d, rv, ph, bz, nw, lw);
        chk(ph == SP0 && bz == 1 && d == 16'h3C5A, "R5 read redirected to spare", ph, SP0);
        do_write(6'd20, 16'hBEEF);
        chk(last_wr == SP0, "R5 write redirected to spare", last_wr, SP0);
        do_read(6'd20, d, rv, ph, bz, nw, lw);
        chk(d == 16'hBEEF, "R5 spare holds new data", int'(d), 16'hBEEF);
    endtask

    task automatic t_spare_fault;
        logic [15:0] d; logic rv; int ph, bz, nw, lw;
        make_stuck(SP0, 9);
        do_read(6'd20, d, rv, ph, bz, nw, lw);
        chk(d == 16'hBEEF && bz == 5, "R6 faulty spare read corrected", int'(d), 16'hBEEF);
        chk(lw == SP0 + 1, "R6 moved to spare 1", lw, SP0 + 1);
        do_read(6'd20, d, rv, ph, bz, nw, lw);
        chk(ph == SP0 + 1 && d == 16'hBEEF, "R6 retired spare not matched", ph, SP0 + 1);
    endtask

    task automatic t_double;
        logic [15:0] d; logic rv; int ph, bz, nw, lw;
        do_write(6'd30, 16'h5555);
        flip_bits(30, 22'h000210);
        do_read(6'd30, d, rv, ph, bz, nw, lw);
        chk(nw == 0 && bz == 1, "R8 no write-back on double error", nw * 10 + bz, 1);
        chk(ue_flag == 1'b1, "R8 ue flag raised", int'(ue_flag), 1);
        do_read(6'd1, d, rv, ph, bz, nw, lw);
        chk(ue_flag == 1'b1, "R8 ue flag sticky", int'(ue_flag), 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(ue_flag == 1'b0, "R8 ue flag cleared", int'(ue_flag), 0);
    endtask

    task automatic t_exhaust;
        logic [15:0] d; logic rv; int ph, bz, nw, lw;
        for (int k = 0; k < 6; k++) begin
            do_write(AW'(40 + k), 16'h0101 * 16'(k + 3));
            make_stuck(40 + k, k + 1);
            do_read(AW'(40 + k), d, rv, ph, bz, nw, lw);
            chk(lw == SP0 + 2 + k && nw == 2, "R5 ascending spare order", lw, SP0 + 2 + k);
        end
        chk(exhaust_flag == 1'b0, "R9 no exhaust while spares remain", int'(exhaust_flag), 0);
        do_write(6'd50, 16'hC0DE);
        make_stuck(50, 12);
        do_read(6'd50, d, rv, ph, bz, nw, lw);
        chk(d == 16'hC0DE && bz == 4 && nw == 1, "R9 exhausted stall and writes", bz * 10 + nw, 41);
        chk(exhaust_flag == 1'b1, "R9 exhaust flag raised", int'(exhaust_flag), 1);
        do_read(6'd50, d, rv, ph, bz, nw, lw);
        chk(ph == 50 && d == 16'hC0DE, "R9 mapping kept, ECC corrects", ph, 50);
        chk(exhaust_flag == 1'b1, "R9 exhaust flag sticky", int'(exhaust_flag), 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(exhaust_flag == 1'b0, "R9 exhaust flag cleared", int'(exhaust_flag), 0);
    endtask

    initial begin
        compared = 0; mismatched = 0; done = 1'b0;
        wr_cnt = 0; last_wr = 0; last_rd = 0;
        req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; flag_clr = 1'b0;
        flip_a = '0; flip_m = '0;
        for (int i = 0; i < PHYS; i++) begin
            stk_m[i] = '0;
            stk_v[i] = '0;
        end
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_soft();
        t_stall();
        t_hard();
        t_spare_fault();
        t_double();
        t_exhaust();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule